// File: doc/BRIEF.md
# Shared-Pin GPIO Port with External Bus Override

This block is an eight-pin general-purpose I/O port whose pads are shared with the low byte of an external system bus. Software reaches it through four small registers. An output value register holds the levels the port drives. A direction register chooses, pin by pin, whether the pin drives or listens. A pin-level view returns the synchronized input levels. A mode register holds a single bus-disable bit.

While the bus-disable bit is clear, which is the state after reset, the pads belong to the external bus and the GPIO registers have no effect on them. The pads then carry either the multiplexed address/data byte, driven under the bus controller's enable, or the upper address byte when address and data are demultiplexed. Once software sets the bus-disable bit, each pad follows its own direction and latch bits. Incoming levels pass through a two-flop synchronizer, which stands in for the input buffer.

Top module: `gpio_bus_port`

## Requirements
- R1: After reset, a read of the latch (address 1) returns 0x00, a read of the direction register (address 2) returns 0xFF, and a read of the mode register (address 3) returns 0x00, so the port starts in bus mode.
- R2: A write to address 0 or address 1 stores the written byte in the output latch. The new value is visible on the next read of address 1.
- R3: A read of address 0 returns the pin input levels through a two-stage synchronizer. A change on `pin_in` before a clock edge shows on the read only after the second rising edge.
- R4: The direction register at address 2 reads back the last value written to it.
- R5: When the bus-disable bit is 1, `pin_oe[i]` is the inverse of direction bit i. `pin_out[i]` equals latch bit i while that pin drives, and it is 0 while the pin is an input (high-impedance).
- R6: In GPIO mode, writing 0xCF to the direction register makes pins 5 and 4 outputs and pins 7, 6 and 3 to 0 inputs, so `pin_oe` equals 0x30.
- R7: When the bus-disable bit is 0 and `bus_muxed` is 1, `pin_out` equals `bus_ad_out` and every bit of `pin_oe` equals `bus_ad_oe`.
- R8: When the bus-disable bit is 0 and `bus_muxed` is 0, `pin_out` equals `bus_addr_hi` and `pin_oe` is 0xFF.
- R9: In bus mode, writes to the latch and direction register are stored but do not change `pin_out` or `pin_oe`. They take effect as soon as the bus-disable bit is set.
- R10: Bit 0 of the mode register (address 3) is the bus-disable bit. It is written by a write to address 3, and it reads back with bits 7 to 1 as zero.
- R11: A read of address 1 returns the latch contents even when the pin levels differ, so read-modify-write on the latch does not pick up the input levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pin levels / latch write, 1 latch, 2 direction, 3 mode |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| bus_muxed | input | 1 | 1 = multiplexed address/data bus, 0 = demultiplexed |
| bus_ad_out | input | 8 | Address/data byte from the bus controller |
| bus_ad_oe | input | 1 | Drive enable for the address/data byte |
| bus_addr_hi | input | 8 | Address bits 15:8 for demultiplexed operation |
| bus_din | output | 8 | Raw pad levels returned to the bus controller |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A corrupted latch or direction bit in GPIO mode shows in the same cycle as a wrong `pin_out` or `pin_oe` bit, and also on the next register read. A mode bit that is wrong turns the pads over to the wrong source right away, and every pad then follows the bus inputs instead of the registers. A synchronizer with the wrong depth shows as a port read that changes one edge too early or too late after a pad change. The directed tests sample on exactly those edges.

// File: rtl/gpio_bus_pkg.sv
package gpio_bus_pkg;

    localparam int PORT_W   = 8;
    localparam int SYNC_LEN = 2;

    typedef enum logic [1:0] {
        REG_PORT  = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_MODE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_GPIO      = 2'd0,
        SRC_BUS_MUX   = 2'd1,
        SRC_BUS_DEMUX = 2'd2
    } drive_src_e;

    function automatic drive_src_e pick_source(input logic bus_off, input logic muxed);
        if (bus_off)
            return SRC_GPIO;
        else if (muxed)
            return SRC_BUS_MUX;
        else
            return SRC_BUS_DEMUX;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bus_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_sel_e     wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic         bus_dis_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= '0;
            dir_q     <= '1;
            bus_dis_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                REG_PORT, REG_LATCH: latch_q   <= wr_data;
                REG_DIR:             dir_q     <= wr_data;
                REG_MODE:            bus_dis_q <= wr_data[0];
                default:             ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_bus_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] synced
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign synced = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_bus_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  drive_src_e   src,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] bus_ad_out,
    input  logic         bus_ad_oe,
    input  logic [W-1:0] bus_addr_hi,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            unique case (src)
                SRC_GPIO: begin
                    pin_oe[i]  = ~dir[i];
                    pin_out[i] = ~dir[i] & latch[i];
                end
                SRC_BUS_MUX: begin
                    pin_oe[i]  = bus_ad_oe;
                    pin_out[i] = bus_ad_out[i];
                end
                default: begin
                    pin_oe[i]  = 1'b1;
                    pin_out[i] = bus_addr_hi[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_bus_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr_en,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wr_data,
    output logic [W-1:0] reg_rd_data,
    input  logic         bus_muxed,
    input  logic [W-1:0] bus_ad_out,
    input  logic         bus_ad_oe,
    input  logic [W-1:0] bus_addr_hi,
    output logic [W-1:0] bus_din,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    reg_sel_e     sel;
    drive_src_e   src;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic         bus_dis_q;
    logic [W-1:0] pin_sync;

    assign sel = reg_sel_e'(reg_addr);

    gpio_regfile #(.W(W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_sel    (sel),
        .wr_data   (reg_wr_data),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .bus_dis_q (bus_dis_q)
    );

    gpio_in_sync #(.W(W), .STAGES(SYNC_LEN)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_in (pin_in),
        .synced (pin_sync)
    );

    assign src = pick_source(bus_dis_q, bus_muxed);

    gpio_pin_mux #(.W(W)) mux_i (
        .src         (src),
        .latch       (latch_q),
        .dir         (dir_q),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_addr_hi (bus_addr_hi),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    assign bus_din = pin_in;

    always_comb begin
        unique case (sel)
            REG_PORT:  reg_rd_data = pin_sync;
            REG_LATCH: reg_rd_data = latch_q;
            REG_DIR:   reg_rd_data = dir_q;
            default:   reg_rd_data = {{(W-1){1'b0}}, bus_dis_q};
        endcase
    end

endmodule

// File: rtl/gpio_bus_port_chk.sv
module gpio_bus_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_wr_en,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wr_data,
    input logic [W-1:0] reg_rd_data,
    input logic         bus_muxed,
    input logic [W-1:0] bus_ad_out,
    input logic         bus_ad_oe,
    input logic [W-1:0] bus_addr_hi,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] dir_q,
    input logic         bus_dis_q
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && dir_q == '1 && !bus_dis_q));

    p_latch_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && (reg_addr == 2'd0 || reg_addr == 2'd1)) |=> latch_q == $past(reg_wr_data));

    p_port_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && reg_addr == 2'd0) |-> reg_rd_data == $past(pin_in, 2));

    p_gpio_drive_r5: assert property (@(posedge clk) disable iff (rst)
        bus_dis_q |-> (pin_oe == ~dir_q && pin_out == (latch_q & ~dir_q)));

    p_bus_muxed_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_dis_q && bus_muxed) |-> (pin_out == bus_ad_out && pin_oe == {W{bus_ad_oe}}));

    p_bus_demux_r8: assert property (@(posedge clk) disable iff (rst)
        (!bus_dis_q && !bus_muxed) |-> (pin_out == bus_addr_hi && pin_oe == '1));

    p_mode_write_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd3) |=> bus_dis_q == $past(reg_wr_data[0]));

endmodule

bind gpio_bus_port gpio_bus_port_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .bus_muxed   (bus_muxed),
    .bus_ad_out  (bus_ad_out),
    .bus_ad_oe   (bus_ad_oe),
    .bus_addr_hi (bus_addr_hi),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .latch_q     (latch_q),
    .dir_q       (dir_q),
    .bus_dis_q   (bus_dis_q)
);

// File: tb/gpio_bus_port_tb.sv
module gpio_bus_port_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wr_data = '0;
    logic [W-1:0] reg_rd_data;
    logic         bus_muxed = 1'b1;
    logic [W-1:0] bus_ad_out = '0;
    logic         bus_ad_oe = 1'b0;
    logic [W-1:0] bus_addr_hi = '0;
    logic [W-1:0] bus_din;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_bus_port #(.W(W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .bus_muxed   (bus_muxed),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_addr_hi (bus_addr_hi),
        .bus_din     (bus_din),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_addr    = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        reg_read(2'd1, v); check("R1", "latch after reset", v, 8'h00);
        reg_read(2'd2, v); check("R1", "dir after reset", v, 8'hFF);
        reg_read(2'd3, v); check("R1", "mode after reset", v, 8'h00);
    endtask

    task automatic t_bus_muxed;
        bus_muxed = 1'b1; bus_ad_out = 8'hA5; bus_ad_oe = 1'b1;
        #1;
        check("R7", "muxed pin_out", pin_out, 8'hA5);
        check("R7", "muxed pin_oe", pin_oe, 8'hFF);
        bus_ad_oe = 1'b0;
        #1;
        check("R7", "muxed pin_oe released", pin_oe, 8'h00);
    endtask

    task automatic t_bus_demux;
        bus_muxed = 1'b0; bus_addr_hi = 8'h3C;
        #1;
        check("R8", "demux pin_out", pin_out, 8'h3C);
        check("R8", "demux pin_oe", pin_oe, 8'hFF);
    endtask

    task automatic t_bus_ignores_regs;
        logic [W-1:0] v;
        reg_write(2'd1, 8'h55);
        reg_write(2'd2, 8'h00);
        #1;
        check("R9", "bus mode pin_out unchanged", pin_out, 8'h3C);
        check("R9", "bus mode pin_oe unchanged", pin_oe, 8'hFF);
        reg_read(2'd1, v); check("R9", "latch stored in bus mode", v, 8'h55);
    endtask

    task automatic t_enter_gpio;
        logic [W-1:0] v;
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, v); check("R10", "mode readback", v, 8'h01);
        check("R5", "gpio pin_out all driving", pin_out, 8'h55);
        check("R5", "gpio pin_oe all driving", pin_oe, 8'hFF);
    endtask

    task automatic t_dir_cf;
        logic [W-1:0] v;
        reg_write(2'd2, 8'hCF);
        reg_read(2'd2, v); check("R4", "dir readback", v, 8'hCF);
        check("R6", "0xCF output enables", pin_oe, 8'h30);
        check("R5", "inputs drive 0", pin_out, 8'h10);
    endtask

    task automatic t_port_write;
        logic [W-1:0] v;
        reg_write(2'd0, 8'hAA);
        reg_read(2'd1, v); check("R2", "latch via port address", v, 8'hAA);
        check("R2", "pin_out after port write", pin_out, 8'h20);
        reg_write(2'd1, 8'hF0);
        reg_read(2'd1, v); check("R2", "latch via latch address", v, 8'hF0);
    endtask

    task automatic t_sync_latency;
        logic [W-1:0] v;
        reg_addr = 2'd0;
        @(negedge clk);
        reg_read(2'd0, v); check("R3", "port before change", v, 8'h00);
        pin_in = 8'h3C;
        #1;
        check("R3", "raw bus_din follows pads", bus_din, 8'h3C);
        @(negedge clk);
        reg_read(2'd0, v); check("R3", "port after one edge", v, 8'h00);
        @(negedge clk);
        reg_read(2'd0, v); check("R3", "port after two edges", v, 8'h3C);
    endtask

    task automatic t_rmw;
        logic [W-1:0] v;
        reg_write(2'd1, 8'hAA);
        pin_in = 8'h0F;
        repeat (3) @(negedge clk);
        reg_read(2'd1, v); check("R11", "latch read ignores pins", v, 8'hAA);
        reg_read(2'd0, v); check("R11", "port read shows pins", v, 8'h0F);
    endtask

    task automatic t_leave_gpio;
        logic [W-1:0] v;
        bus_muxed = 1'b1; bus_ad_out = 8'h69; bus_ad_oe = 1'b1;
        reg_write(2'd3, 8'hFE);
        reg_read(2'd3, v); check("R10", "mode cleared via bit 0", v, 8'h00);
        check("R7", "back to bus pin_out", pin_out, 8'h69);
        check("R7", "back to bus pin_oe", pin_oe, 8'hFF);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bus_muxed();
        t_bus_demux();
        t_bus_ignores_regs();
        t_enter_gpio();
        t_dir_cf();
        t_port_write();
        t_sync_latency();
        t_rmw();
        t_leave_gpio();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule